// File: doc/BRIEF.md
# Li-Ion Charge Mode Sequencer

This block picks the charging regime for a single lithium-ion cell. It never touches analogue quantities. Cell voltage, charge current, temperature and the thermistor reading arrive as 8-bit sampled codes with a one-cycle valid strobe. A digital flag reports whether charger input voltage is present, and a periodic tick (1 ms nominal) times how long that flag has been steady. From these inputs the block walks through a fixed order of states: a dead-cell probe, a small-current trickle phase, a precharge phase run purely by hardware, and a fast phase started by software. The fast phase first holds a constant current and then a constant voltage. The walk ends in a done, dead or fault state.

The outputs are a current setpoint code, a constant-voltage enable, a charge enable and a state code. External regulation circuitry turns these into transistor drive. Decisions are taken only when a new sample has been evaluated, except for loss of charger voltage, which acts on the next clock edge from any state. The thermistor code also serves to detect whether a cell is present: a reading at or above the open-circuit threshold means no cell is fitted.

Top module: `cell_charge_sequencer`

## Requirements
- R1: After reset the state code is 0 (idle), the setpoint code is 0 (off), and both the charge enable and the constant-voltage enable are low.
- R2: In idle, with charger voltage present, an evaluated sample whose thermistor code is below 240 moves the block to state 1 (probe), which drives setpoint code 1 (small current).
- R3: In probe, the next evaluated sample with cell present moves the block to state 7 (dead, setpoint 0) if the voltage code is below 20. Otherwise it moves to state 2 (trickle, setpoint 1).
- R4: In trickle, a sample with voltage code above 60 moves the block to state 3 (precharge, setpoint 2). Lower codes keep it in trickle.
- R5: In precharge, the temperature code and the current code have no effect: the block stays in state 3 whatever their values, unless the fast-start condition of R6 holds.
- R6: Precharge moves to state 4 (constant current, setpoint 3) only on a sample with voltage code above 124, taken while the software-start input is high and while the charger has been qualified. Qualification means more than 10 ticks have been counted since charger voltage last became present.
- R7: Any dropout of charger voltage restarts the qualification count from zero, so ticks counted before the dropout do not count toward R6.
- R8: In state 4, a sample with voltage code at or above the cv_target input moves the block to state 5 (constant voltage, setpoint 3, constant-voltage enable high).
- R9: In state 4 or 5, a sample with voltage code above 176, current code above 200, or temperature code outside 40..90 inclusive moves the block to state 8 (fault, setpoint 0). This check has priority over R8 and R10.
- R10: In state 5, a sample with current code below 10 moves the block to state 6 (done, setpoint 0). In state 4 a low current code has no effect.
- R11: A sample with thermistor code of 240 or more in state 1, 2, 3, 4 or 5 returns the block to idle with charge disabled.
- R12: Charger voltage absent at a clock edge puts the block in idle at that edge from any state, overriding any sample evaluated in the same cycle.
- R13: States 6, 7 and 8 hold while charger voltage stays present, whatever the samples say, and clear only to idle by R12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per qualification time unit |
| chg_in_ok | input | 1 | Charger input voltage present |
| sw_start | input | 1 | Software permits the fast phase |
| meas_valid | input | 1 | Measurement codes are valid this cycle |
| vbat_code | input | 8 | Sampled cell voltage |
| ibat_code | input | 8 | Sampled charge current |
| temp_code | input | 8 | Sampled temperature |
| therm_code | input | 8 | Sampled thermistor reading (also cell presence) |
| cv_target | input | 8 | Voltage code at which constant voltage begins |
| chg_en | output | 1 | Charging path enabled |
| cv_en | output | 1 | Constant-voltage regulation selected |
| iset_code | output | 2 | Current setpoint: 0 off, 1 small, 2 precharge, 3 fast |
| status | output | 4 | State code as listed in the requirements |

## Verification
Two things can land on the same clock edge: a sample being evaluated and a charger dropout. Either one alone would move the state somewhere else. The bench sets up this collision by first driving the block into constant-current charge. It then issues a sample with an out-of-window temperature, which alone would cause a fault, and drops charger voltage exactly in the cycle when that sample's flags are acted upon. The block must land in idle, not in fault. A second overlap, a fault limit crossed together with the constant-voltage target in one sample, is judged by the vbat sweep in constant current: codes above 176 must give fault even though they also exceed the target.

// File: rtl/chg_pkg.sv
package chg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_PROBE   = 4'd1,
        ST_TRICKLE = 4'd2,
        ST_PRECHG  = 4'd3,
        ST_FAST_CC = 4'd4,
        ST_FAST_CV = 4'd5,
        ST_DONE    = 4'd6,
        ST_DEAD    = 4'd7,
        ST_FAULT   = 4'd8
    } chg_state_e;

    typedef enum logic [1:0] {
        ISET_OFF   = 2'd0,
        ISET_SMALL = 2'd1,
        ISET_PRE   = 2'd2,
        ISET_FAST  = 2'd3
    } iset_e;

    typedef struct packed {
        logic batt_ok;
        logic v_dead;
        logic v_trk;
        logic v_boot;
        logic v_ovp;
        logic i_ocp;
        logic t_ok;
        logic v_cv;
        logic i_taper;
    } meas_flags_t;

endpackage

// File: rtl/chg_presence_qual.sv
module chg_presence_qual #(
    parameter int unsigned QUAL_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_in_ok,
    input  logic tick,
    output logic qualified
);
    localparam int unsigned CNT_W = $clog2(QUAL_TICKS + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_TICKS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } qual_regs_t;

    qual_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!chg_in_ok) begin
            r_d.cnt = '0;
        end else if (tick && (r_q.cnt != CNT_MAX)) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign qualified = (r_q.cnt == CNT_MAX);

endmodule

// File: rtl/chg_meas_eval.sv
module chg_meas_eval
    import chg_pkg::*;
#(
    parameter int unsigned ADC_W      = 8,
    parameter int unsigned V_DEAD     = 20,
    parameter int unsigned V_TRICKLE  = 60,
    parameter int unsigned V_BOOT     = 124,
    parameter int unsigned V_OVP      = 176,
    parameter int unsigned I_TAPER    = 10,
    parameter int unsigned I_OCP      = 200,
    parameter int unsigned T_LO       = 40,
    parameter int unsigned T_HI       = 90,
    parameter int unsigned THERM_OPEN = 240
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_valid,
    input  logic [ADC_W-1:0] vbat_code,
    input  logic [ADC_W-1:0] ibat_code,
    input  logic [ADC_W-1:0] temp_code,
    input  logic [ADC_W-1:0] therm_code,
    input  logic [ADC_W-1:0] cv_target,
    output meas_flags_t      flags,
    output logic             flags_vld
);
    localparam logic [ADC_W-1:0] V_DEAD_C  = ADC_W'(V_DEAD);
    localparam logic [ADC_W-1:0] V_TRK_C   = ADC_W'(V_TRICKLE);
    localparam logic [ADC_W-1:0] V_BOOT_C  = ADC_W'(V_BOOT);
    localparam logic [ADC_W-1:0] V_OVP_C   = ADC_W'(V_OVP);
    localparam logic [ADC_W-1:0] I_TAPER_C = ADC_W'(I_TAPER);
    localparam logic [ADC_W-1:0] I_OCP_C   = ADC_W'(I_OCP);
    localparam logic [ADC_W-1:0] T_LO_C    = ADC_W'(T_LO);
    localparam logic [ADC_W-1:0] T_HI_C    = ADC_W'(T_HI);
    localparam logic [ADC_W-1:0] TH_OPEN_C = ADC_W'(THERM_OPEN);

    typedef struct packed {
        meas_flags_t f;
        logic        vld;
    } eval_regs_t;

    eval_regs_t  r_d, r_q;
    meas_flags_t cmp;

    always_comb begin
        cmp.batt_ok = (therm_code < TH_OPEN_C);
        cmp.v_dead  = (vbat_code < V_DEAD_C);
        cmp.v_trk   = (vbat_code > V_TRK_C);
        cmp.v_boot  = (vbat_code > V_BOOT_C);
        cmp.v_ovp   = (vbat_code > V_OVP_C);
        cmp.i_ocp   = (ibat_code > I_OCP_C);
        cmp.t_ok    = (temp_code >= T_LO_C) && (temp_code <= T_HI_C);
        cmp.v_cv    = (vbat_code >= cv_target);
        cmp.i_taper = (ibat_code < I_TAPER_C);

        r_d     = r_q;
        r_d.vld = meas_valid;
        if (meas_valid) begin
            r_d.f = cmp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign flags     = r_q.f;
    assign flags_vld = r_q.vld;

endmodule

// File: rtl/chg_mode_fsm.sv
module chg_mode_fsm
    import chg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        chg_in_ok,
    input  logic        pres_qual,
    input  logic        sw_start,
    input  meas_flags_t flags,
    input  logic        flags_vld,
    output logic [3:0]  status,
    output logic [1:0]  iset_code,
    output logic        cv_en,
    output logic        chg_en
);
    typedef struct packed {
        chg_state_e st;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;
    logic      limit_hit;
    iset_e     iset;

    always_comb begin
        limit_hit = flags.v_ovp || flags.i_ocp || !flags.t_ok;
        r_d = r_q;
        if (!chg_in_ok) begin
            r_d.st = ST_IDLE;
        end else if (flags_vld) begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (flags.batt_ok) r_d.st = ST_PROBE;
                end
                ST_PROBE: begin
                    if (!flags.batt_ok)   r_d.st = ST_IDLE;
                    else if (flags.v_dead) r_d.st = ST_DEAD;
                    else                   r_d.st = ST_TRICKLE;
                end
                ST_TRICKLE: begin
                    if (!flags.batt_ok)   r_d.st = ST_IDLE;
                    else if (flags.v_trk) r_d.st = ST_PRECHG;
                end
                ST_PRECHG: begin
                    if (!flags.batt_ok) r_d.st = ST_IDLE;
                    else if (flags.v_boot && pres_qual && sw_start) r_d.st = ST_FAST_CC;
                end
                ST_FAST_CC: begin
                    if (!flags.batt_ok)   r_d.st = ST_IDLE;
                    else if (limit_hit)   r_d.st = ST_FAULT;
                    else if (flags.v_cv)  r_d.st = ST_FAST_CV;
                end
                ST_FAST_CV: begin
                    if (!flags.batt_ok)     r_d.st = ST_IDLE;
                    else if (limit_hit)     r_d.st = ST_FAULT;
                    else if (flags.i_taper) r_d.st = ST_DONE;
                end
                default: r_d.st = r_q.st;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.st)
            ST_PROBE, ST_TRICKLE:   iset = ISET_SMALL;
            ST_PRECHG:              iset = ISET_PRE;
            ST_FAST_CC, ST_FAST_CV: iset = ISET_FAST;
            default:                iset = ISET_OFF;
        endcase
    end

    assign status    = r_q.st;
    assign iset_code = iset;
    assign cv_en     = (r_q.st == ST_FAST_CV);
    assign chg_en    = (iset != ISET_OFF);

endmodule

// File: rtl/cell_charge_sequencer.sv
module cell_charge_sequencer
    import chg_pkg::*;
#(
    parameter int unsigned ADC_W      = 8,
    parameter int unsigned QUAL_TICKS = 10,
    parameter int unsigned V_DEAD     = 20,
    parameter int unsigned V_TRICKLE  = 60,
    parameter int unsigned V_BOOT     = 124,
    parameter int unsigned V_OVP      = 176,
    parameter int unsigned I_TAPER    = 10,
    parameter int unsigned I_OCP      = 200,
    parameter int unsigned T_LO       = 40,
    parameter int unsigned T_HI       = 90,
    parameter int unsigned THERM_OPEN = 240
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             chg_in_ok,
    input  logic             sw_start,
    input  logic             meas_valid,
    input  logic [ADC_W-1:0] vbat_code,
    input  logic [ADC_W-1:0] ibat_code,
    input  logic [ADC_W-1:0] temp_code,
    input  logic [ADC_W-1:0] therm_code,
    input  logic [ADC_W-1:0] cv_target,
    output logic             chg_en,
    output logic             cv_en,
    output logic [1:0]       iset_code,
    output logic [3:0]       status
);
    logic        pres_qual;
    meas_flags_t flags;
    logic        flags_vld;

    chg_presence_qual #(
        .QUAL_TICKS(QUAL_TICKS)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .chg_in_ok (chg_in_ok),
        .tick      (tick),
        .qualified (pres_qual)
    );

    chg_meas_eval #(
        .ADC_W     (ADC_W),
        .V_DEAD    (V_DEAD),
        .V_TRICKLE (V_TRICKLE),
        .V_BOOT    (V_BOOT),
        .V_OVP     (V_OVP),
        .I_TAPER   (I_TAPER),
        .I_OCP     (I_OCP),
        .T_LO      (T_LO),
        .T_HI      (T_HI),
        .THERM_OPEN(THERM_OPEN)
    ) u_eval (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_valid (meas_valid),
        .vbat_code  (vbat_code),
        .ibat_code  (ibat_code),
        .temp_code  (temp_code),
        .therm_code (therm_code),
        .cv_target  (cv_target),
        .flags      (flags),
        .flags_vld  (flags_vld)
    );

    chg_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .chg_in_ok (chg_in_ok),
        .pres_qual (pres_qual),
        .sw_start  (sw_start),
        .flags     (flags),
        .flags_vld (flags_vld),
        .status    (status),
        .iset_code (iset_code),
        .cv_en     (cv_en),
        .chg_en    (chg_en)
    );

endmodule

// File: rtl/chg_seq_checker.sv
module chg_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       chg_in_ok,
    input logic       qual,
    input logic [3:0] status,
    input logic       cv_en
);
    // R12: charger loss forces idle at the next edge
    a_r12_dropout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_in_ok |=> (status == 4'd0));

    // R13: fault persists while charger stays present
    a_r13_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((status == 4'd8) && chg_in_ok) |=> (status == 4'd8));

    // R6: fast phase is entered only from a qualified precharge
    a_r6_fast_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ((status == 4'd4) && ($past(status) != 4'd4)) |-> (($past(status) == 4'd3) && $past(qual)));

    // R8: constant voltage follows constant current
    a_r8_cv_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cv_en) |-> ($past(status) == 4'd4));

    // R10: done is reached only from constant voltage
    a_r10_done_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ((status == 4'd6) && ($past(status) != 4'd6)) |-> ($past(status) == 4'd5));

    // R9 and R5: fault is reached only from the fast phase
    a_r9_fault_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ((status == 4'd8) && ($past(status) != 4'd8)) |-> (($past(status) == 4'd4) || ($past(status) == 4'd5)));

    // R3: dead is reached only from the probe
    a_r3_dead_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ((status == 4'd7) && ($past(status) != 4'd7)) |-> ($past(status) == 4'd1));

endmodule

bind cell_charge_sequencer chg_seq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chg_in_ok (chg_in_ok),
    .qual      (pres_qual),
    .status    (status),
    .cv_en     (cv_en)
);

// File: tb/cell_charge_sequencer_tb.sv
`timescale 1ns/1ps
module cell_charge_sequencer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       chg_in_ok = 1'b0;
    logic       sw_start = 1'b0;
    logic       meas_valid = 1'b0;
    logic [7:0] vbat_code = '0;
    logic [7:0] ibat_code = '0;
    logic [7:0] temp_code = '0;
    logic [7:0] therm_code = '0;
    logic [7:0] cv_target = 8'd160;
    logic       chg_en;
    logic       cv_en;
    logic [1:0] iset_code;
    logic [3:0] status;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;

    always #2.5 clk = ~clk;

    cell_charge_sequencer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .chg_in_ok  (chg_in_ok),
        .sw_start   (sw_start),
        .meas_valid (meas_valid),
        .vbat_code  (vbat_code),
        .ibat_code  (ibat_code),
        .temp_code  (temp_code),
        .therm_code (therm_code),
        .cv_target  (cv_target),
        .chg_en     (chg_en),
        .cv_en      (cv_en),
        .iset_code  (iset_code),
        .status     (status)
    );

    task automatic check(input string tag, input int exp_st);
        int exp_iset;
        bit exp_cv;
        bit exp_en;
        exp_iset = (exp_st == 1 || exp_st == 2) ? 1 :
                   (exp_st == 3) ? 2 :
                   (exp_st == 4 || exp_st == 5) ? 3 : 0;
        exp_cv = (exp_st == 5);
        exp_en = (exp_iset != 0);
        n_chk++;
        if (int'(status) != exp_st || int'(iset_code) != exp_iset ||
            cv_en != exp_cv || chg_en != exp_en) begin
            n_bad++;
            $display("FAIL %s: status=%0d exp %0d iset=%0d exp %0d cv=%0d exp %0d en=%0d exp %0d",
                     tag, status, exp_st, iset_code, exp_iset, cv_en, exp_cv, chg_en, exp_en);
        end
    endtask

    task automatic sample(input int v, input int i, input int t, input int th);
        @(negedge clk);
        vbat_code  = 8'(v);
        ibat_code  = 8'(i);
        temp_code  = 8'(t);
        therm_code = 8'(th);
        meas_valid = 1'b1;
        @(negedge clk);
        meas_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic give_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic to_idle();
        @(negedge clk); chg_in_ok = 1'b0; sw_start = 1'b0;
        @(negedge clk); chg_in_ok = 1'b1;
    endtask

    task automatic to_probe();
        to_idle();
        sample(100, 50, 60, 100);
    endtask

    task automatic to_trickle();
        to_probe();
        sample(40, 50, 60, 100);
    endtask

    task automatic to_pre();
        to_trickle();
        sample(100, 50, 60, 100);
    endtask

    task automatic to_cc();
        to_pre();
        give_ticks(11);
        sw_start = 1'b1;
        sample(130, 50, 60, 100);
    endtask

    task automatic to_cv();
        to_cc();
        sample(165, 50, 60, 100);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual=hung expected=completed");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 0);

        // R2: start probe
        to_probe();
        check("R2 probe entry", 1);
        // R2: absent cell keeps idle
        to_idle();
        sample(100, 50, 60, 240);
        check("R2 absent cell stays idle", 0);

        // R3: dead threshold sweep
        for (int v = 0; v < 256; v++) begin
            to_probe();
            sample(v, 50, 60, 100);
            check("R3 probe vbat sweep", (v < 20) ? 7 : 2);
        end

        // R4: trickle exit sweep
        for (int v = 0; v < 256; v++) begin
            to_trickle();
            sample(v, 50, 60, 100);
            check("R4 trickle vbat sweep", (v > 60) ? 3 : 2);
        end

        // R5: temperature and current ignored in precharge
        to_pre();
        for (int t = 0; t < 256; t++) begin
            sample(100, 255 - t, t, 100);
            check("R5 precharge limits ignored", 3);
        end

        // R6: boot voltage sweep with qualification and start
        for (int v = 0; v < 256; v++) begin
            to_pre();
            give_ticks(11);
            sw_start = 1'b1;
            sample(v, 50, 60, 100);
            check("R6 boot vbat sweep", (v > 124) ? 4 : 3);
        end

        // R6: software start required
        to_pre();
        give_ticks(11);
        sample(130, 50, 60, 100);
        check("R6 no sw_start holds precharge", 3);
        sw_start = 1'b1;
        sample(130, 50, 60, 100);
        check("R6 sw_start enters fast", 4);

        // R6: exactly 10 ticks is not enough
        to_pre();
        give_ticks(10);
        sw_start = 1'b1;
        sample(130, 50, 60, 100);
        check("R6 ten ticks insufficient", 3);
        give_ticks(1);
        sample(130, 50, 60, 100);
        check("R6 eleventh tick qualifies", 4);

        // R7: dropout restarts qualification
        to_idle();
        give_ticks(6);
        @(negedge clk); chg_in_ok = 1'b0;
        @(negedge clk); chg_in_ok = 1'b1;
        sample(100, 50, 60, 100);
        sample(40, 50, 60, 100);
        sample(100, 50, 60, 100);
        give_ticks(6);
        sw_start = 1'b1;
        sample(130, 50, 60, 100);
        check("R7 count restarted after dropout", 3);
        give_ticks(5);
        sample(130, 50, 60, 100);
        check("R7 qualifies after fresh count", 4);

        // R8, R9: vbat sweep in constant current
        for (int v = 0; v < 256; v++) begin
            to_cc();
            sample(v, 50, 60, 100);
            check("R8 R9 cc vbat sweep", (v > 176) ? 8 : (v >= 160) ? 5 : 4);
        end

        // R9: temperature window sweep in constant current
        for (int t = 0; t < 256; t++) begin
            to_cc();
            sample(130, 50, t, 100);
            check("R9 cc temp sweep", (t >= 40 && t <= 90) ? 4 : 8);
        end

        // R9, R10: current sweep in constant current (taper ignored)
        for (int i = 0; i < 256; i++) begin
            to_cc();
            sample(130, i, 60, 100);
            check("R9 R10 cc ibat sweep", (i > 200) ? 8 : 4);
        end

        // R9, R10: current sweep in constant voltage
        for (int i = 0; i < 256; i++) begin
            to_cv();
            sample(165, i, 60, 100);
            check("R9 R10 cv ibat sweep", (i > 200) ? 8 : (i < 10) ? 6 : 5);
        end

        // R11: cell removal in charging states
        to_trickle();
        sample(40, 50, 60, 250);
        check("R11 removal in trickle", 0);
        to_cv();
        sample(165, 50, 60, 240);
        check("R11 removal in cv", 0);

        // R12: plain dropout
        to_trickle();
        @(negedge clk); chg_in_ok = 1'b0;
        @(negedge clk);
        check("R12 dropout to idle", 0);
        chg_in_ok = 1'b1;

        // R12: dropout collides with a fault sample
        to_cc();
        @(negedge clk);
        vbat_code = 8'd130; ibat_code = 8'd50; temp_code = 8'd0; therm_code = 8'd100;
        meas_valid = 1'b1;
        @(negedge clk);
        meas_valid = 1'b0;
        chg_in_ok = 1'b0;
        @(negedge clk);
        check("R12 dropout beats fault sample", 0);
        chg_in_ok = 1'b1;

        // R13: terminal states hold until charger removal
        to_cc();
        sample(130, 50, 0, 100);
        check("R13 fault entered", 8);
        sample(130, 50, 60, 100);
        check("R13 fault holds on good sample", 8);
        @(negedge clk); chg_in_ok = 1'b0;
        @(negedge clk);
        check("R13 fault clears on removal", 0);
        chg_in_ok = 1'b1;
        to_probe();
        sample(5, 50, 60, 100);
        sample(100, 50, 60, 100);
        check("R13 dead holds", 7);
        to_cv();
        sample(165, 5, 60, 100);
        sample(130, 50, 60, 250);
        check("R13 done holds", 6);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule